// File: doc/BRIEF.md
# Resumable Sub-Region State Machine

This block is one concurrent region of a hierarchical controller. A coordinating machine outside the block raises a single activity line while the composite state that owns this region is active. While that line is high, the region steps through four working states under the control of guard inputs, and it drives Moore outputs decoded from whichever working state it is in. When the line drops, the region leaves its working state and enters a parked state.

There is one parked state for each working state. The parked state therefore records where the region was when its parent was left. When the activity line rises again, the region returns to the recorded working state instead of starting over. A parameter turns this history off, so that every parked state leads back to the initial working state.

States: working states S0, S1, S2 and S3, and parked states I0, I1, I2 and I3. The encoding is {parked bit, index}. S0 to S3 are 3'b000 to 3'b011, and I0 to I3 are 3'b100 to 3'b111. Transitions:

- step01, step12, step23 and step30 move Sk to S(k+1) (S3 wraps to S0) when the guard bit for that state is high.
- parkK moves Sk to Ik when the activity line is low.
- resumeK moves Ik to Sk when the activity line is high, or Ik to S0 when history is off.
- Reset picks S0 or I0.

Top module: `rgn_hist_fsm`

## Requirements
- R1: On a clock edge with `rst` high, the region enters S0 if `act_i` is high and I0 if `act_i` is low. From I0, a rising `act_i` leads to S0.
- R2: In working state Sk with `act_i` high and `guard_i[k]` high, the next edge moves the region to S(k+1). From S3 it wraps to S0.
- R3: In working state Sk with `act_i` high and `guard_i[k]` low, the region stays in Sk. The guard bits belonging to other states have no effect.
- R4: In working state Sk with `act_i` low, the next edge moves the region to parked state Ik, and `y_o` reads 0 in every parked state.
- R5: In a parked state with `act_i` low, the region stays in that state whatever `guard_i` holds.
- R6: With `HIST_EN`=1, a parked state Ik with `act_i` high moves to Sk on the next edge. The guards are not considered on that edge.
- R7: With `HIST_EN`=0, every parked state moves to S0 when `act_i` is high.
- R8: The outputs are decoded from the state alone. With the default map, S0 gives 4'b0001, S1 gives 4'b0010, S2 gives 4'b0110 and S3 gives 4'b1001.
- R9: A low `act_i` takes priority over a high guard: Sk goes to Ik, not to S(k+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled and the state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| act_i | input | 1 | Activity line from the coordinating machine |
| guard_i | input | 4 | Bit k is the guard for leaving Sk towards S(k+1) |
| y_o | output | OUT_W (4) | Moore outputs of the current state |

## Verification
The bound checker checks on every cycle that the region:

- parks in the matching idle state when the activity line is low;
- steps or holds according to the guard bit of its current state only;
- stays put while parked;
- resumes in the recorded state, or in S0 with history off;
- keeps its outputs at zero while parked.

Only the bench's scenarios can show the absolute output codes of each working state, the reset choice between S0 and I0, and full resume sequences that cross the wrap from S3 to S0. The bench also compares the history and non-history variants under identical stimulus.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    localparam int unsigned NUM_WORK = 4;
    localparam int unsigned IDX_W    = $clog2(NUM_WORK);
    localparam int unsigned ST_W     = IDX_W + 1;

    // {parked bit, index}: the index of a parked state names the working
    // state it returns to, so the encoding carries the history itself.
    typedef enum logic [ST_W-1:0] {
        ST_S0 = 3'b000,
        ST_S1 = 3'b001,
        ST_S2 = 3'b010,
        ST_S3 = 3'b011,
        ST_I0 = 3'b100,
        ST_I1 = 3'b101,
        ST_I2 = 3'b110,
        ST_I3 = 3'b111
    } rgn_state_e;

endpackage

// File: rtl/rgn_next.sv
module rgn_next
    import rgn_pkg::*;
#(
    parameter bit HIST_EN = 1'b1
) (
    input  rgn_state_e            cur_i,
    input  logic                  act_i,
    input  logic [NUM_WORK-1:0]   guard_i,
    output rgn_state_e            nxt_o
);

    // Choose where each parked state resumes.
    localparam rgn_state_e RES0 = ST_S0;
    localparam rgn_state_e RES1 = HIST_EN ? ST_S1 : ST_S0;
    localparam rgn_state_e RES2 = HIST_EN ? ST_S2 : ST_S0;
    localparam rgn_state_e RES3 = HIST_EN ? ST_S3 : ST_S0;

    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            // Working states: a low activity line wins over the guard.
            ST_S0: begin
                if (!act_i)          nxt_o = ST_I0;   // park0
                else if (guard_i[0]) nxt_o = ST_S1;   // step01
            end
            ST_S1: begin
                if (!act_i)          nxt_o = ST_I1;   // park1
                else if (guard_i[1]) nxt_o = ST_S2;   // step12
            end
            ST_S2: begin
                if (!act_i)          nxt_o = ST_I2;   // park2
                else if (guard_i[2]) nxt_o = ST_S3;   // step23
            end
            ST_S3: begin
                if (!act_i)          nxt_o = ST_I3;   // park3
                else if (guard_i[3]) nxt_o = ST_S0;   // step30
            end
            // Parked states: only the activity line matters.
            ST_I0: if (act_i) nxt_o = RES0;           // resume0
            ST_I1: if (act_i) nxt_o = RES1;           // resume1
            ST_I2: if (act_i) nxt_o = RES2;           // resume2
            ST_I3: if (act_i) nxt_o = RES3;           // resume3
            default: nxt_o = ST_I0;
        endcase
    end

endmodule

// File: rtl/rgn_outdec.sv
module rgn_outdec
    import rgn_pkg::*;
#(
    parameter int unsigned              OUT_W   = 4,
    parameter logic [NUM_WORK*OUT_W-1:0] OUT_MAP = 16'b1001_0110_0010_0001
) (
    input  rgn_state_e         st_i,
    output logic [OUT_W-1:0]   y_o
);

    // Slice k of OUT_MAP holds the output word of working state Sk.
    logic [OUT_W-1:0] word_w [NUM_WORK];

    for (genvar k = 0; k < NUM_WORK; k++) begin : g_word
        assign word_w[k] = OUT_MAP[k*OUT_W +: OUT_W];
    end

    always_comb begin
        y_o = '0;
        unique case (st_i)
            ST_S0: y_o = word_w[0];
            ST_S1: y_o = word_w[1];
            ST_S2: y_o = word_w[2];
            ST_S3: y_o = word_w[3];
            ST_I0, ST_I1, ST_I2, ST_I3: y_o = '0;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/rgn_hist_fsm.sv
module rgn_hist_fsm
    import rgn_pkg::*;
#(
    parameter bit                        HIST_EN = 1'b1,
    parameter int unsigned               OUT_W   = 4,
    parameter logic [NUM_WORK*OUT_W-1:0] OUT_MAP = 16'b1001_0110_0010_0001
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                act_i,
    input  logic [NUM_WORK-1:0] guard_i,
    output logic [OUT_W-1:0]    y_o
);

    rgn_state_e st_q;
    rgn_state_e st_d;

    rgn_next #(
        .HIST_EN (HIST_EN)
    ) next_i (
        .cur_i   (st_q),
        .act_i   (act_i),
        .guard_i (guard_i),
        .nxt_o   (st_d)
    );

    // State register; reset lands in S0 or I0 depending on the parent.
    always_ff @(posedge clk) begin
        if (rst) st_q <= act_i ? ST_S0 : ST_I0;
        else     st_q <= st_d;
    end

    rgn_outdec #(
        .OUT_W   (OUT_W),
        .OUT_MAP (OUT_MAP)
    ) outdec_i (
        .st_i (st_q),
        .y_o  (y_o)
    );

endmodule

// File: rtl/rgn_hist_fsm_chk.sv
module rgn_hist_fsm_chk
    import rgn_pkg::*;
#(
    parameter bit          HIST_EN = 1'b1,
    parameter int unsigned OUT_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                act_i,
    input logic [NUM_WORK-1:0] guard_i,
    input logic [OUT_W-1:0]    y_o,
    input logic [ST_W-1:0]     st
);

    wire             parked = st[ST_W-1];
    wire [IDX_W-1:0] idx    = st[IDX_W-1:0];

    // R2: a taken guard advances the index by one, wrapping
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (act_i && !parked && guard_i[idx]) |=>
            (!parked && idx == IDX_W'($past(idx) + 1'b1)));

    // R3: an untaken own guard holds the working state
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (act_i && !parked && !guard_i[idx]) |=> $stable(st));

    // R4, R9: a low activity line parks in the matching idle state
    assert_park_R4: assert property (@(posedge clk) disable iff (rst)
        (!act_i && !parked) |=> (parked && idx == $past(idx)));

    // R4: parked states drive no outputs
    assert_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        parked |-> (y_o == '0));

    // R5: parked with a low activity line stays put
    assert_stay_R5: assert property (@(posedge clk) disable iff (rst)
        (!act_i && parked) |=> $stable(st));

    // R6 and R7: resume in the recorded state, or in S0 without history
    assert_resume_R6: assert property (@(posedge clk) disable iff (rst)
        (act_i && parked) |=>
            (!parked && idx == (HIST_EN ? $past(idx) : IDX_W'(0))));

endmodule

bind rgn_hist_fsm rgn_hist_fsm_chk #(
    .HIST_EN (HIST_EN),
    .OUT_W   (OUT_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .act_i   (act_i),
    .guard_i (guard_i),
    .y_o     (y_o),
    .st      (st_q)
);

// File: tb/rgn_hist_fsm_tb_top.sv
module rgn_hist_fsm_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       act = 1'b0;
    logic [3:0] grd = 4'b0000;
    logic [3:0] y_h;
    logic [3:0] y_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rgn_hist_fsm #(.HIST_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .act_i(act), .guard_i(grd), .y_o(y_h));

    rgn_hist_fsm #(.HIST_EN(1'b0)) dut_nh (
        .clk(clk), .rst(rst), .act_i(act), .guard_i(grd), .y_o(y_n));

    // Entry: {act, guard[3:0], expected y after the edge}, history on.
    // Output codes (R8): S0=0001 S1=0010 S2=0110 S3=1001, parked=0000.
    localparam int NV = 19;
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 4'b0000, 4'b0001},  // R3 S0 holds
        {1'b1, 4'b1110, 4'b0001},  // R3 foreign guards ignored
        {1'b1, 4'b0001, 4'b0010},  // R2 step01
        {1'b1, 4'b0000, 4'b0010},  // R3 S1 holds
        {1'b1, 4'b0010, 4'b0110},  // R2 step12
        {1'b0, 4'b0100, 4'b0000},  // R9 park wins over guard -> I2
        {1'b0, 4'b1111, 4'b0000},  // R5 parked, guards ignored
        {1'b0, 4'b0000, 4'b0000},  // R5
        {1'b1, 4'b0000, 4'b0110},  // R6 resume2 -> S2
        {1'b1, 4'b0100, 4'b1001},  // R2 step23
        {1'b1, 4'b1000, 4'b0001},  // R2 step30 wrap
        {1'b1, 4'b0001, 4'b0010},  // R2
        {1'b0, 4'b0000, 4'b0000},  // R4 park1
        {1'b1, 4'b0000, 4'b0010},  // R6 resume1
        {1'b1, 4'b0010, 4'b0110},  // R2
        {1'b1, 4'b0100, 4'b1001},  // R8 S3 code
        {1'b0, 4'b0000, 4'b0000},  // R4 park3
        {1'b1, 4'b1000, 4'b1001},  // R6 guard not used on resume edge
        {1'b1, 4'b1000, 4'b0001}   // R2 wrap after resume
    };

    task automatic check(input string tag, input logic [3:0] act_v, input logic [3:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: y=%b expected %b", tag, act_v, exp_v);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, then sample.
    task automatic step(input logic a, input logic [3:0] g);
        @(negedge clk);
        act = a;
        grd = g;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic a);
        @(negedge clk);
        rst = 1'b1;
        act = a;
        grd = 4'b0000;
        @(posedge clk);
        #2;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        // R1: reset with the parent inactive lands in I0
        do_reset(1'b0);
        check("R1 reset to I0", y_h, 4'b0000);
        step(1'b0, 4'b1111);
        check("R5 I0 stays", y_h, 4'b0000);
        step(1'b1, 4'b0000);
        check("R1 I0 -> S0", y_h, 4'b0001);

        // Vector walk, history variant
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8], VEC[i][7:4]);
            check($sformatf("R8 vector %0d", i), y_h, VEC[i][3:0]);
        end

        // R1: reset while in S0 with parent active; also from S2
        step(1'b1, 4'b0001);
        step(1'b1, 4'b0010);
        check("R2 reach S2", y_h, 4'b0110);
        do_reset(1'b1);
        check("R1 reset to S0", y_h, 4'b0001);

        // R7: the non-history variant resumes in S0
        step(1'b1, 4'b0001);
        check("R7 nh step01", y_n, 4'b0010);
        step(1'b1, 4'b0010);
        check("R7 nh step12", y_n, 4'b0110);
        step(1'b0, 4'b0000);
        check("R7 nh parked", y_n, 4'b0000);
        check("R4 hist parked", y_h, 4'b0000);
        step(1'b1, 4'b0000);
        check("R7 nh resume to S0", y_n, 4'b0001);
        check("R6 hist resume to S2", y_h, 4'b0110);

        // R9: park wins from S3 with its guard high
        step(1'b1, 4'b0100);
        check("R2 S2 -> S3", y_h, 4'b1001);
        step(1'b0, 4'b1000);
        check("R9 S3 parks", y_h, 4'b0000);
        step(1'b1, 4'b0000);
        check("R6 back to S3", y_h, 4'b1001);

        finish_run();
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: y=%b expected run end", y_h);
        finish_run();
    end

endmodule